// File: doc/BRIEF.md
# Overflow Watchdog Pulse Timer

This block is an up-counting timer used as a watchdog. Software loads a start value, a compare value and a control word. While the timer runs, each timer tick moves the counter forward. A compare match sets a compare flag. When the counter wraps past all ones it sets an overflow flag and drives a one-tick pulse on an external pin. The pin is meant to be wired to a reset input, so once the pulse ends the pin keeps its active level and its output enable for a fixed number of fast-clock cycles. That holds the reset long enough to be valid.

The block runs on `clk`, which is twice the internal clock rate, so the 2.5-internal-clock hold becomes five `clk` cycles. `tick` is a one-cycle enable produced outside the block, either from the internal clock divided by two or from a prescaler. Writes go through a small port. `wr_sel` 0 is the control word, 1 is the load value, 2 is the compare value and 3 clears flags.

Top module: `wdt_pulse_timer`

## Requirements
- R1: The control word holds these fields: bits 3:0 are the mode, bit 4 is enable, bit 5 is reload-on-compare, bit 6 is invert, bit 7 is the compare interrupt enable and bit 8 is the overflow interrupt enable. The timer runs only when the mode is 4'b1001 and enable is 1. While it does not run, the counter follows the load value, ticks have no effect and `pin_oe` is 0 unless a hold is in progress.
- R2: While running, a tick increments the counter by one, modulo 2^24, unless R4 applies.
- R3: The compare flag sets on the tick that moves the counter onto the compare value. `cmp_irq` equals the compare flag AND control bit 7.
- R4: With reload-on-compare set, a tick that finds the counter equal to the compare value loads the load value instead of incrementing.
- R5: A tick that finds the counter at all ones, with no reload, wraps the counter to 0 and sets the overflow flag. `ovf_irq` equals the overflow flag AND control bit 8.
- R6: Overflow starts a pulse on `pin_out` that lasts until the next tick. The active level equals the invert bit (1 means high, 0 means low). The idle level is the opposite.
- R7: When the pulse ends, whether by a tick or because the timer is disabled, `pin_out` keeps the active level and `pin_oe` stays 1 for 5 more `clk` cycles, even while the timer is disabled.
- R8: Writing the load value (`wr_sel`=1) while running puts the written value into the counter on the same edge.
- R9: Writing `wr_sel`=3 clears the compare flag when bit 0 is 1 and the overflow flag when bit 1 is 1. A bit written as 0 leaves its flag unchanged.
- R10: After reset, the count is 0, both flags and both interrupts are 0, `pin_oe` is 0 and `pin_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the internal rate |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 load, 2 compare, 3 flag clear |
| wr_data | input | 24 | Write data |
| tick | input | 1 | One-cycle timer tick enable |
| count | output | 24 | Current counter value |
| cmp_flag | output | 1 | Compare flag |
| ovf_flag | output | 1 | Overflow flag |
| cmp_irq | output | 1 | Compare interrupt |
| ovf_irq | output | 1 | Overflow interrupt |
| pin_out | output | 1 | Watchdog pin level |
| pin_oe | output | 1 | Watchdog pin output enable |

## Verification
Counter, flag and pulse results appear one `clk` cycle after the edge that takes the tick or the write. The bench drives inputs on falling edges and reads outputs on the next falling edge, which is exactly one register stage later. The hold window is checked at its last active cycle (4 cycles after a tick ends the pulse, 5 after a disable write) and again one cycle later, when the pin must have returned to idle or floating. Vector entries count ticks from the enable write, so every expected count is known from the start value alone.

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
  parameter int W = 24,
  parameter int HOLD = 5,
  parameter logic [3:0] MODE_SEL = 4'b1001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         cmp_flag,
  output logic         ovf_flag,
  output logic         cmp_irq,
  output logic         ovf_irq,
  output logic         pin_out,
  output logic         pin_oe
);
  localparam int HW = $clog2(HOLD + 1);

  logic [8:0]    ctrl_q;
  logic [W-1:0]  load_q, cmp_q, cnt_q, cnt_nxt;
  logic          pulse_q, pol_q;
  logic [HW-1:0] hold_q;

  wire wr_ctrl = wr_en && (wr_sel == 2'd0);
  wire wr_load = wr_en && (wr_sel == 2'd1);
  wire wr_cmp  = wr_en && (wr_sel == 2'd2);
  wire wr_clr  = wr_en && (wr_sel == 2'd3);

  wire active    = (ctrl_q[3:0] == MODE_SEL) && ctrl_q[4];
  wire do_reload = ctrl_q[5] && (cnt_q == cmp_q);
  wire step      = active && tick && !wr_load;
  wire ovf_evt   = step && !do_reload && (&cnt_q);
  wire pulse_end = pulse_q && (tick || !active);
  wire pin_drive = pulse_q || (hold_q != '0);

  assign cnt_nxt = do_reload ? load_q : cnt_q + W'(1);
  wire cmp_evt = step && (cnt_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[8:0];
      if (wr_load) load_q <= wr_data;
      if (wr_cmp)  cmp_q  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= load_q;
    else if (wr_load) cnt_q <= wr_data;
    else if (step)    cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cmp_flag <= cmp_evt || (cmp_flag && !(wr_clr && wr_data[0]));
      ovf_flag <= ovf_evt || (ovf_flag && !(wr_clr && wr_data[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pol_q   <= 1'b0;
      hold_q  <= '0;
    end else if (ovf_evt) begin
      pulse_q <= 1'b1;
      pol_q   <= ctrl_q[6];
      hold_q  <= '0;
    end else if (pulse_end) begin
      pulse_q <= 1'b0;
      hold_q  <= HW'(HOLD);
    end else if (hold_q != '0) begin
      hold_q  <= hold_q - HW'(1);
    end
  end

  assign count   = cnt_q;
  assign cmp_irq = cmp_flag && ctrl_q[7];
  assign ovf_irq = ovf_flag && ctrl_q[8];
  assign pin_out = pin_drive ? pol_q : !ctrl_q[6];
  assign pin_oe  = active || pin_drive;
endmodule

// File: rtl/wdt_pulse_timer_chk.sv
module wdt_pulse_timer_chk #(
  parameter int W = 24,
  parameter int HW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  cnt_q,
  input logic [W-1:0]  cmp_q,
  input logic [W-1:0]  load_q,
  input logic [8:0]    ctrl_q,
  input logic          active,
  input logic          pol_q,
  input logic [HW-1:0] hold_q,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          ovf_flag
);
  wire ld  = wr_en && (wr_sel == 2'd1);
  wire rl  = ctrl_q[5] && (cnt_q == cmp_q);
  wire adv = active && tick && !ld;

  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !rl |=> cnt_q == $past(cnt_q) + W'(1)); // R2
  AST_RELOAD_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && rl |=> cnt_q == $past(load_q)); // R4
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !rl && (&cnt_q) |=> ovf_flag && cnt_q == '0); // R5
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !rl && (&cnt_q) |=> pin_oe && pin_out == $past(ctrl_q[6])); // R6
  AST_HOLD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q != '0 |-> pin_oe && pin_out == pol_q); // R7
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    active && ld |=> cnt_q == $past(wr_data)); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd3 && wr_data[1] && !tick |=> !ovf_flag); // R9
endmodule

bind wdt_pulse_timer wdt_pulse_timer_chk #(.W(W), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .cnt_q(cnt_q), .cmp_q(cmp_q), .load_q(load_q),
  .ctrl_q(ctrl_q), .active(active), .pol_q(pol_q), .hold_q(hold_q),
  .pin_out(pin_out), .pin_oe(pin_oe), .ovf_flag(ovf_flag)
);

// File: tb/wdt_pulse_timer_tb.sv
module wdt_pulse_timer_tb;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic [23:0] count;
  logic cmp_flag, ovf_flag, cmp_irq, ovf_irq, pin_out, pin_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam int M9 = 9, EN = 16, RL = 32, INV = 64, CIE = 128, OIE = 256;

  // load, compare, reload, ticks, expected count, expected compare flag
  localparam int NV = 6;
  localparam logic [81:0] VEC [NV] = '{
    {24'd10, 24'd20, 1'b0, 8'd5, 24'd15, 1'b0},
    {24'd10, 24'd12, 1'b1, 8'd2, 24'd12, 1'b1},
    {24'd10, 24'd12, 1'b1, 8'd3, 24'd10, 1'b1},
    {24'd10, 24'd12, 1'b1, 8'd4, 24'd11, 1'b1},
    {24'd10, 24'd12, 1'b0, 8'd4, 24'd14, 1'b1},
    {24'd0,  24'd3,  1'b1, 8'd9, 24'd1,  1'b1}
  };

  always #2 clk = !clk;

  wdt_pulse_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .count(count), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 24'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ld, input int cmp, input int ctrl);
    wr(2'd0, M9);
    wr(2'd1, ld);
    wr(2'd2, cmp);
    wr(2'd3, 3);
    idle(1);
    wr(2'd0, ctrl);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk(count == 0 && !cmp_flag && !ovf_flag && !cmp_irq && !ovf_irq, "R10 reset regs", int'(count), 0);
    chk(!pin_oe && pin_out, "R10 reset pin", int'({pin_oe, pin_out}), 1);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v = VEC[i];
      setup(int'(v[81:58]), int'(v[57:34]), M9 | EN | (v[33] ? RL : 0));
      for (int t = 0; t < int'(v[32:25]); t++) tick_once();
      chk(count == v[24:1], $sformatf("R2 R4 vector %0d count", i), int'(count), int'(v[24:1]));
      chk(cmp_flag == v[0], $sformatf("R3 vector %0d flag", i), int'(cmp_flag), int'(v[0]));
    end

    setup(50, 51, M9 | EN | CIE);
    tick_once();
    chk(cmp_irq, "R3 compare irq", int'(cmp_irq), 1);

    setup(50, 900, 4'b0001 | EN);
    tick_once(); tick_once();
    chk(count == 50 && !pin_oe, "R1 wrong mode ignores ticks", int'(count), 50);
    wr(2'd0, M9 | EN);
    chk(pin_oe, "R1 enable drives pin", int'(pin_oe), 1);

    wr(2'd1, 100);
    chk(count == 100, "R8 load write while running", int'(count), 100);

    setup(24'hFFFFFE, 5, M9 | EN | OIE);
    tick_once();
    chk(count == 24'hFFFFFF && pin_out, "R6 idle level before overflow", int'(pin_out), 1);
    tick_once();
    chk(count == 0 && ovf_flag && ovf_irq, "R5 wrap and flag", int'(count), 0);
    chk(!pin_out && pin_oe, "R6 active-low pulse", int'(pin_out), 0);
    idle(3);
    chk(!pin_out, "R6 pulse lasts until next tick", int'(pin_out), 0);
    tick_once();
    idle(4);
    chk(!pin_out && pin_oe, "R7 hold last cycle", int'(pin_out), 0);
    idle(1);
    chk(pin_out, "R7 hold released", int'(pin_out), 1);
    chk(count == 1, "R2 count continues after wrap", int'(count), 1);

    wr(2'd3, 1);
    chk(ovf_flag, "R9 zero bit keeps flag", int'(ovf_flag), 1);
    wr(2'd3, 2);
    chk(!ovf_flag && !ovf_irq, "R9 clear overflow flag", int'(ovf_flag), 0);

    setup(24'hFFFFFF, 5, M9 | EN | INV);
    chk(!pin_out, "R6 inverted idle level", int'(pin_out), 0);
    tick_once();
    chk(pin_out && ovf_flag, "R6 active-high pulse", int'(pin_out), 1);
    wr(2'd0, M9 | INV);
    idle(5);
    chk(pin_oe && pin_out, "R7 hold after disable", int'({pin_oe, pin_out}), 3);
    idle(1);
    chk(!pin_oe, "R7 float after hold", int'(pin_oe), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule